// File: doc/BRIEF.md
# Edge-Latched Single-Bit Static RAM

This block models a 4096-location memory, one bit wide, in which every access is framed by an active-low chip enable. When the enable goes low, the block captures the address into an internal register. For the rest of that access the address pins are ignored, so a bus may move on to the next address without disturbing the access in progress. A low write enable during the access stores the data input into the addressed cell. A high write enable during the access reads the cell into an output register, and the output flag then marks the data pin as driven. The flag is the stand-in for a three-state pin: when it is low, the pin is high impedance.

The cells form a square of 64 rows by 64 columns. Two groups of three address bits select the row, and the remaining two groups select the column. The row and column selects act only during an enabled access. A system clock samples the enable and write strobes, so every edge and latch in the model becomes a clocked register. The contents are static: with the enable held high, stored bits persist without any maintenance.

Top module: `edge_sram`

## Requirements
- R1: Each of the 4096 addresses holds its own bit. The row is {addr[8:6], addr[2:0]} and the column is {addr[11:9], addr[5:3]}. Addresses that differ in any single bit, including the top and bottom addresses, keep independent values.
- R2: The address is sampled at the first clock edge that sees ce_n low after it was high. Changes on addr after that edge have no effect on the access in progress.
- R3: A clock edge with ce_n low and we_n low, inside an access already started at an earlier edge, stores din into the addressed cell. The last such edge of the access decides the stored bit.
- R4: Once we_n has been sampled low in an access, dout_en stays 0 until that access ends, even if we_n returns high.
- R5: In a read access (we_n high), dout_en becomes 1 at the second clock edge after ce_n falls, and dout carries the addressed cell.
- R6: While dout_en stays 1, dout does not change.
- R7: At every clock edge that samples ce_n high, dout_en goes to 0, and no cell is written whatever we_n and din do.
- R8: After reset, dout_en is 0 and the block waits for a falling enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low; its falling edge starts an access |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Cell address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data |
| dout_en | output | 1 | Output driven; low means the pin is high impedance |

## Verification
The address capture and a change on the address pins can fall in the same access. The bench therefore moves addr to a cell that holds the opposite bit in the clock cycle right after the enable edge, and judges the read by the value of the captured cell, not the new one. A second coincidence, a write strobe arriving while a read would otherwise assert the output, is provoked by first stepping din through both values and then raising we_n before the access ends. In that case the output must stay off and the final din must be the stored bit.

// File: rtl/edge_sram.sv
module edge_sram #(
  parameter int GRP = 3,
  localparam int AW = 4 * GRP,
  localparam int SIDE = 2 * GRP,
  localparam int N = 1 << SIDE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          dout,
  output logic          dout_en
);

  logic [N-1:0]    cells [N];
  logic            ce_s, active, wr_seen, q_r, oe;
  logic [AW-1:0]   addr_r;
  logic [SIDE-1:0] row, col;

  assign row = {addr_r[3*GRP-1:2*GRP], addr_r[GRP-1:0]};
  assign col = {addr_r[4*GRP-1:3*GRP], addr_r[2*GRP-1:GRP]};

  wire wr_go = active && !ce_n && !we_n;

  always_ff @(posedge clk)
    if (wr_go) cells[row][col] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_s <= 1'b1;
      active <= 1'b0;
      wr_seen <= 1'b0;
      addr_r <= '0;
      q_r <= 1'b0;
      oe <= 1'b0;
    end else begin
      ce_s <= ce_n;
      if (ce_n) begin
        active <= 1'b0;
        wr_seen <= 1'b0;
        oe <= 1'b0;
      end else begin
        if (ce_s) begin
          active <= 1'b1;
          addr_r <= addr;
          wr_seen <= 1'b0;
        end
        if (active) begin
          if (!we_n) begin
            wr_seen <= 1'b1;
            oe <= 1'b0;
          end else if (!wr_seen) begin
            q_r <= cells[row][col];
            oe <= 1'b1;
          end
        end
      end
    end

  assign dout = q_r;
  assign dout_en = oe;

endmodule

module edge_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic dout,
  input logic dout_en
);
  AST_OFF_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) ce_n |=> !dout_en); // R7
  AST_OFF_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !we_n |=> !dout_en); // R4
  AST_HOLD_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n) (dout_en && $past(dout_en)) |-> $stable(dout)); // R6
  AST_ON_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) $rose(dout_en) |-> ($past(!ce_n) && $past(we_n))); // R5
endmodule

bind edge_sram edge_sram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .dout(dout), .dout_en(dout_en)
);

// File: tb/edge_sram_tb_top.sv
`timescale 1ns/1ps
module edge_sram_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [11:0] addr = '0;
  logic dout, dout_en;
  int tests = 0, fails = 0;
  bit model [int];
  bit exp_q[$];
  string tag_q[$];
  bit prev_en = 1'b0;

  always #2 clk = ~clk;

  edge_sram dut_i (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
                   .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dout_en && !prev_en) begin
      if (exp_q.size() == 0) check("R5 unexpected output", 1'b1, 1'b0);
      else check(tag_q.pop_front(), dout, exp_q.pop_front());
    end
    prev_en = dout_en;
  end

  task automatic do_write(input logic [11:0] a, input bit b);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = ~b;
    @(negedge clk); addr = ~a; check("R4 off at write start", dout_en, 1'b0);
    @(negedge clk); din = b; check("R4 off mid write", dout_en, 1'b0);
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); check("R4 off after W rises", dout_en, 1'b0);
    ce_n = 1'b1;
    @(negedge clk);
    model[int'(a)] = b;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [11:0] glitch, input string req);
    exp_q.push_back(model[int'(a)]);
    tag_q.push_back(req);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk); addr = glitch; check("R5 not yet driven", dout_en, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 held enable", dout_en, 1'b1);
      check("R6 held data", dout, model[int'(a)]);
    end
    ce_n = 1'b1;
    @(negedge clk); check("R7 off after deselect", dout_en, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset output off", dout_en, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); check("R8 idle after reset", dout_en, 1'b0);
    do_write(12'h000, 1'b1);
    do_write(12'h001, 1'b0);
    do_write(12'h008, 1'b0);
    do_write(12'h040, 1'b0);
    do_write(12'h200, 1'b0);
    do_write(12'h800, 1'b0);
    do_write(12'hFFF, 1'b1);
    do_write(12'hFFE, 1'b0);
    do_write(12'h041, 1'b1);
    do_read(12'h000, 12'h001, "R1 addr 000");
    do_read(12'h001, 12'h000, "R2 glitch ignored 001");
    do_read(12'h008, 12'h000, "R1 column bit A3");
    do_read(12'h040, 12'h041, "R2 glitch ignored 040");
    do_read(12'h200, 12'hFFF, "R1 column bit A9");
    do_read(12'h800, 12'h000, "R1 column bit A11");
    do_read(12'hFFF, 12'hFFE, "R1 top address");
    do_read(12'hFFE, 12'hFFF, "R1 addr FFE");
    do_read(12'h041, 12'h040, "R1 row bits A0 A6");
    @(negedge clk); ce_n = 1'b1; we_n = 1'b0; addr = 12'h000; din = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 no output while deselected", dout_en, 1'b0);
    we_n = 1'b1;
    do_read(12'h000, 12'h001, "R7 deselected write ignored");
    do_write(12'h000, 1'b0);
    do_read(12'h000, 12'hFFF, "R3 overwrite last din wins");
    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", exp_q.size() == 0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule